// File: doc/BRIEF.md
# Handshake-Driven Latch Enable Sequencer

This block computes the enables of an N-stage linear latch pipeline without a global clock phase. Each latch has its own small controller. The controller opens or closes its latch only when tokens from its direct neighbours permit it. The whole arrangement is a marked graph. Every ordering arc holds a one-bit token, and every latch has a rising event (open, transparent) and a falling event (close, capture). The model is cycle-level. On each clock edge, a pair of request vectors names the rising and falling events to attempt. Events that are enabled and requested fire together on that edge, and requests for events that are not enabled are dropped.

Nothing in the marked graph forces two phases to stay apart. Neighbouring latches can therefore be transparent at the same time while a data token ripples through them. The data source in front of stage 0 and the sink behind stage N-1 are an always-ready environment. The sink returns its token one cycle after the last latch closes. The block has no data path, so all pins are plain control and status vectors with no valid/ready handshake. Bit i of every vector belongs to stage i, and stage 0 is the input end. The stage count N must be even and at least 2.

Top module: `dsync_ctrl_gen`

## Requirements
- R1: While rst_n is low and after it is released, until the first firing, lat_en is all zeros, fall_en is all zeros, and rise_en has bit i set exactly for odd i (1, 3, 5, ...). Those are the stages holding bubbles, ready to capture from the even stages that hold data.
- R2: A latch's enable changes only on an edge where its enabled event was requested. A rise is only ever enabled while the latch is closed and a fall only while it is open, so rises and falls of one latch alternate strictly.
- R3: For i < N-1, rising event i is enabled only if latch i+1 has fallen since the last rise of latch i, or since reset for the odd stages.
- R4: For i > 0, falling event i is enabled only if latch i-1 has risen since the last fall of latch i. For the even stages the data token present at reset counts as that rise.
- R5: Falling event 0 needs nothing but latch 0 being open, because the input environment always supplies data.
- R6: The sink behind stage N-1 returns its token one cycle after the fall of latch N-1. If that fall fires on edge t, rise_en[N-1] is low between edges t and t+1 and may be high again only after edge t+1.
- R7: A request for an event that is not enabled has no effect. lat_en, rise_en and fall_en after the edge are what they would be without that request.
- R8: All requested and enabled events fire on the same edge, whatever their number, and each one's enable changes on that edge.
- R9: With N = 4, requesting from reset the events rise 3, fall 3, rise 2 and rise 1, one per cycle, is legal. It leaves lat_en = 4'b0110, with latches 1 and 2 transparent together.
- R10: No ordering arc ever receives a token while it already holds one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the cycle-level model |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rise | input | N | Per-stage request to fire the rising (open) event |
| req_fall | input | N | Per-stage request to fire the falling (close) event |
| lat_en | output | N | Latch enables, 1 = transparent |
| rise_en | output | N | Rising events currently enabled |
| fall_en | output | N | Falling events currently enabled |

## Verification
The bench builds the block with N = 4. At that size the directed sequence of R9, with two adjacent latches open together, can be checked exactly against its stated end state. The reachable state space is also small enough that several thousand random request vectors visit every token arrangement many times, including simultaneous firings at both ends and the one-cycle sink return of R6. Both latch-0 rules and last-stage rules are exercised, because with four stages the first and last controllers are separated by two interior ones.

// File: rtl/dsync_pkg.sv
package dsync_pkg;

  // Stages with an odd index hold a bubble at reset and are ready to open.
  function automatic logic bubble_at_reset(input int idx);
    return (idx % 2) == 1;
  endfunction

  // An even stage holds a data token at reset, so the arc from it to its
  // successor's fall starts marked.
  function automatic logic data_at_reset(input int idx);
    return (idx % 2) == 0;
  endfunction

  typedef struct packed {
    logic rise_en;
    logic fall_en;
    logic rise_fire;
    logic fall_fire;
  } stage_evt_t;

endpackage

// File: rtl/dsync_place.sv
module dsync_place #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic put,
  input  logic take,
  output logic tok
);
  logic tok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tok_q <= INIT;
    else        tok_q <= (tok_q & ~take) | put;
  end

  assign tok = tok_q;
endmodule

// File: rtl/dsync_env_return.sv
module dsync_env_return (
  input  logic clk,
  input  logic rst_n,
  input  logic last_fall,
  input  logic take,
  output logic tok
);
  logic pend_q;
  logic tok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tok_q  <= 1'b1;
    end else begin
      pend_q <= last_fall;
      tok_q  <= (tok_q & ~take) | pend_q;
    end
  end

  assign tok = tok_q;
endmodule

// File: rtl/dsync_latch_ctl.sv
module dsync_latch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_tok,
  input  logic fall_tok,
  input  logic req_rise,
  input  logic req_fall,
  output logic level,
  output dsync_pkg::stage_evt_t evt
);
  logic level_q;
  logic r_en, f_en, r_go, f_go;

  always_comb begin
    r_en = ~level_q & rise_tok;
    f_en =  level_q & fall_tok;
    r_go = r_en & req_rise;
    f_go = f_en & req_fall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            level_q <= 1'b0;
    else if (r_go || f_go) level_q <= ~level_q;
  end

  assign level = level_q;
  assign evt   = '{rise_en: r_en, fall_en: f_en, rise_fire: r_go, fall_fire: f_go};
endmodule

// File: rtl/dsync_ctrl_gen.sv
module dsync_ctrl_gen #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_rise,
  input  logic [N-1:0] req_fall,
  output logic [N-1:0] lat_en,
  output logic [N-1:0] rise_en,
  output logic [N-1:0] fall_en
);
  import dsync_pkg::*;

  localparam int NARC = (N > 1) ? N - 1 : 1;

  stage_evt_t      evt [N];
  logic [N-1:0]    rise_fire, fall_fire;
  logic [N-1:0]    bk_tok;   // fall of i+1 -> rise of i; last entry from sink
  logic [NARC-1:0] fw_tok;   // rise of i -> fall of i+1
  logic [N-1:0]    fall_need;

  for (genvar i = 0; i < N; i++) begin : g_stage
    dsync_latch_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_tok (bk_tok[i]),
      .fall_tok (fall_need[i]),
      .req_rise (req_rise[i]),
      .req_fall (req_fall[i]),
      .level    (lat_en[i]),
      .evt      (evt[i])
    );
    assign rise_en[i]   = evt[i].rise_en;
    assign fall_en[i]   = evt[i].fall_en;
    assign rise_fire[i] = evt[i].rise_fire;
    assign fall_fire[i] = evt[i].fall_fire;

    if (i == 0) begin : g_head
      assign fall_need[i] = 1'b1;
    end else begin : g_body
      assign fall_need[i] = fw_tok[i-1];
    end
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_arc
    dsync_place #(.INIT(bubble_at_reset(i))) u_bk (
      .clk (clk), .rst_n (rst_n),
      .put (fall_fire[i+1]), .take (rise_fire[i]), .tok (bk_tok[i])
    );
    dsync_place #(.INIT(data_at_reset(i))) u_fw (
      .clk (clk), .rst_n (rst_n),
      .put (rise_fire[i]), .take (fall_fire[i+1]), .tok (fw_tok[i])
    );
  end

  if (N == 1) begin : g_no_arc
    assign fw_tok = '0;
  end

  dsync_env_return u_sink (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_fall (fall_fire[N-1]),
    .take      (rise_fire[N-1]),
    .tok       (bk_tok[N-1])
  );
endmodule

// File: rtl/dsync_ctrl_chk.sv
module dsync_ctrl_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_rise,
  input logic [N-1:0] req_fall,
  input logic [N-1:0] lat_en,
  input logic [N-1:0] rise_en,
  input logic [N-1:0] fall_en,
  input logic [N-1:0] rise_fire,
  input logic [N-1:0] fall_fire,
  input logic [N-1:0] bk_tok
);
  // R1
  reset_pattern_chk: assert property (@(posedge clk)
    !rst_n |=> (lat_en == '0 && fall_en == '0));

  // R2
  alt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_en & lat_en) == '0) && ((fall_en & ~lat_en) == '0));

  // R7
  no_spurious_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((lat_en ^ $past(lat_en)) &
               ~$past((rise_en & req_rise) | (fall_en & req_fall))) == '0);

  // R8
  all_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((lat_en ^ $past(lat_en)) ==
               $past((rise_en & req_rise) | (fall_en & req_fall))));

  // R6
  sink_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_fire[N-1] |=> !rise_en[N-1]);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bk_tok[N-1] & ~rise_fire[N-1]) == 1'b0) || !$past(fall_fire[N-1]));
endmodule

bind dsync_ctrl_gen dsync_ctrl_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_rise  (req_rise),
  .req_fall  (req_fall),
  .lat_en    (lat_en),
  .rise_en   (rise_en),
  .fall_en   (fall_en),
  .rise_fire (rise_fire),
  .fall_fire (fall_fire),
  .bk_tok    (bk_tok)
);

// File: tb/dsync_ctrl_gen_test.sv
module dsync_ctrl_gen_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_rise = '0, req_fall = '0;
  logic [N-1:0] lat_en, rise_en, fall_en;

  int vectors = 0, fails = 0;
  bit done = 0;

  // Behavioural reference: token counts per arc as integers.
  int lv [N];
  int bk [N];
  int fw [N];
  int pend;

  always #10 clk = ~clk;

  dsync_ctrl_gen #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_rise(req_rise), .req_fall(req_fall),
    .lat_en(lat_en), .rise_en(rise_en), .fall_en(fall_en)
  );

  function automatic logic [N-1:0] m_lat();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (lv[i] != 0);
    return v;
  endfunction

  function automatic logic [N-1:0] m_rise();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (lv[i] == 0) && (bk[i] > 0);
    return v;
  endfunction

  function automatic logic [N-1:0] m_fall();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (lv[i] != 0) && (i == 0 || fw[i-1] > 0);
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      lv[i] = 0;
      bk[i] = (i % 2 == 1) ? 1 : 0;
      fw[i] = (i % 2 == 0) ? 1 : 0;
    end
    pend = 0;
  endtask

  task automatic model_step(input logic [N-1:0] rq, input logic [N-1:0] fq);
    logic [N-1:0] rf, ff;
    rf = m_rise() & rq;
    ff = m_fall() & fq;
    for (int i = 0; i < N; i++) if (rf[i] || ff[i]) lv[i] = 1 - lv[i];
    for (int i = 0; i < N - 1; i++) begin
      if (rf[i]) begin bk[i]--; fw[i]++; end
      if (ff[i+1]) begin fw[i]--; bk[i]++; end
      if (bk[i] > 1 || fw[i] > 1) begin
        fails++;
        $display("FAIL R10 model arc %0d overfull: bk=%0d fw=%0d expected <=1", i, bk[i], fw[i]);
      end
    end
    if (rf[N-1]) bk[N-1]--;
    if (pend != 0) bk[N-1]++;
    pend = ff[N-1] ? 1 : 0;
  endtask

  task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check_vec({req, " lat_en"},  lat_en,  m_lat());
    check_vec({req, " rise_en"}, rise_en, m_rise());
    check_vec({req, " fall_en"}, fall_en, m_fall());
  endtask

  // Called just after a negedge: drive, advance through posedge, sample at next negedge.
  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] fq, input string req);
    req_rise = rq;
    req_fall = fq;
    @(posedge clk);
    model_step(rq, fq);
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_rise = '0;
    req_fall = '0;
    model_reset();
    repeat (2) @(negedge clk);
    check_vec("R1 reset lat_en", lat_en, '0);
    check_vec("R1 reset rise_en", rise_en, 4'b1010);
    check_vec("R1 reset fall_en", fall_en, '0);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R7: stage 0 rise and stage 1 fall are disabled at reset
    step(4'b0001, 4'b0010, "R7 disabled requests");
    check_vec("R7 state unchanged", lat_en, 4'b0000);

    // R9 directed sequence: D+ D- C+ B+
    step(4'b1000, 4'b0000, "R9 D+");
    check_vec("R2 D opened", lat_en, 4'b1000);
    step(4'b0000, 4'b1000, "R9 D-");
    check_vec("R6 sink not yet returned", rise_en[3], 1'b0);
    step(4'b0100, 4'b0000, "R9 C+");
    check_vec("R6 sink token back", rise_en[3], 1'b1);
    step(4'b0010, 4'b0000, "R9 B+");
    check_vec("R9 final overlap", lat_en, 4'b0110);
    // R4: C may fall only after B rose (it did); R3: B can't reopen before C falls
    check_vec("R4 C fall enabled", fall_en[2], 1'b1);
    // R5: stage 0 fall needs only open level -- open stage 0 first
    step(4'b0001, 4'b0000, "R3 A+ blocked until B falls");
    check_vec("R3 A still closed", lat_en[0], 1'b0);
    step(4'b0000, 4'b0110, "R8 B- and C- together");
    check_vec("R8 both closed", lat_en, 4'b0000);
    step(4'b0001, 4'b0000, "R3 A+ after B-");
    check_vec("R5 A fall enabled", fall_en[0], 1'b1);
    step(4'b0000, 4'b0001, "R5 A-");
    check_vec("R5 A closed", lat_en[0], 1'b0);

    // Random walk, R2 R3 R4 R6 R7 R8 R10 compared every clock
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] rq, fq;
      rq = N'($urandom);
      fq = N'($urandom);
      step(rq, fq, "R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule